// File: doc/BRIEF.md
# Flash Access Range Error Checker

This block sits beside a serial flash controller and screens every access against the size of the attached flash device. The size is programmed as a 5-bit code, and the device holds 2^(code+1) bytes. Two kinds of access are screened. Register-driven accesses, which are indirect reads and writes and status polling, are checked when the trigger strobe arrives. Memory-mapped bus requests are checked one request at a time.

When a register-driven access is out of range, the block sets a sticky transfer-error flag and withholds the transfer start pulse. The flag drives an interrupt when the interrupt enable is set. A faulty memory-mapped request does not touch the flag. It gets a bus-error response one cycle after the request. A memory-mapped request also gets a bus error when the controller is disabled or when the controller is not in memory-mapped mode.

The serial engine, the FIFOs and the register file are outside this block. It only consumes their programmed values and strobes.

Top module: `flashRangeGuard`

## Requirements
- R1: The device size in bytes is 2^(sizeCode+1). Addresses 0 to size−1 are valid, and code 31 makes the whole 32-bit address space valid.
- R2: The opMode encoding is 0 = indirect write, 1 = indirect read, 2 = status polling, 3 = memory-mapped. In modes 0, 1 and 2, a trigger with progAddr at or above the size sets xferErrFlag, which is visible the cycle after the trigger.
- R3: In modes 0 and 1 with a nonzero dataLen, the trigger also sets xferErrFlag when progAddr + dataLen − 1 is at or above the size. The sum is computed without wrap-around. Mode 2 does not check the length, and a dataLen of 0 means that only the address is checked.
- R4: A trigger that is accepted and passes the checks gives a one-cycle xferStart pulse in the following cycle. A trigger that is flagged gives no xferStart.
- R5: xferErrFlag stays set until clearErr is asserted. When an error is being set and clearErr is asserted in the same cycle, the flag ends up set.
- R6: xferErrIrq is high exactly when xferErrFlag and errIntEnable are both high.
- R7: A trigger has no effect when ctrlEnable is low or when opMode is 3: it produces no xferStart and no change to xferErrFlag.
- R8: An mmValid request in cycle N gives mmReady high in cycle N+1 only. mmBusErr is high with mmReady when mmAddr is at or above the size.
- R9: An mmValid request gets mmBusErr when ctrlEnable is low or when opMode is not 3, whatever its address.
- R10: After reset, xferErrFlag, xferStart, mmReady and mmBusErr are all low.
- R11: A memory-mapped bus error leaves xferErrFlag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sizeCode | input | 5 | Device size code; the size is 2^(code+1) bytes |
| opMode | input | 2 | Operating mode (0 ind. write, 1 ind. read, 2 polling, 3 memory-mapped) |
| ctrlEnable | input | 1 | Controller enable |
| errIntEnable | input | 1 | Transfer-error interrupt enable |
| progAddr | input | 32 | Programmed start address |
| dataLen | input | 32 | Programmed data length in bytes |
| trigger | input | 1 | Access trigger strobe |
| clearErr | input | 1 | Clear strobe for the error flag |
| xferStart | output | 1 | One-cycle pulse that starts an accepted transfer |
| xferErrFlag | output | 1 | Sticky transfer-error flag |
| xferErrIrq | output | 1 | Transfer-error interrupt |
| mmValid | input | 1 | Memory-mapped request valid |
| mmAddr | input | 32 | Memory-mapped request address |
| mmReady | output | 1 | Memory-mapped response valid |
| mmBusErr | output | 1 | Bus-error response |

## Verification
The bench targets the exact size boundary. It uses a last byte that lands on size−1 and one that lands on size, at the smallest code and at a middle code. A design with an off-by-one in the compare would flag the legal case or pass the illegal one. At code 31 it uses an address of all ones together with a length of 2, and a checker whose adder wraps would accept this access. It also checks that polling mode and a zero length skip the length check, that set wins over a clear in the same cycle, and that a memory-mapped fault leaves the flag alone. A design that mixes up the two reporting paths would raise the interrupt flag on a bus request.

// File: rtl/frg_pkg.sv
package frg_pkg;

  typedef enum logic [1:0] {
    MODE_IND_WR = 2'd0,
    MODE_IND_RD = 2'd1,
    MODE_POLL   = 2'd2,
    MODE_MMAP   = 2'd3
  } frgMode_e;

  typedef struct packed {
    logic setErr;
    logic clrErr;
    logic startXfer;
    logic mmRespond;
    logic mmFault;
  } frgStrobes_t;

endpackage

// File: rtl/frg_datapath.sv
module frg_datapath
  import frg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] sizeCode,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic [ADDR_W-1:0] mmAddr,
  input  frgStrobes_t       strb,
  output logic              addrOver,
  output logic              lastOver,
  output logic              lenNonZero,
  output logic              mmAddrOver,
  output logic              errFlag,
  output logic              startPulse,
  output logic              mmReady,
  output logic              mmBusErr
);

  // Two spare bits: one so the size 2^ADDR_W fits, one so the sum cannot wrap.
  localparam int WIDE_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2;

  logic [CODE_W:0]   shiftAmt;
  logic [WIDE_W-1:0] sizeBytes;
  logic [WIDE_W-1:0] lastByte;

  always_comb begin
    shiftAmt   = {1'b0, sizeCode} + {{CODE_W{1'b0}}, 1'b1};
    sizeBytes  = WIDE_W'(1) << shiftAmt;
    lenNonZero = |dataLen;
    lastByte   = WIDE_W'(progAddr) + WIDE_W'(dataLen) - WIDE_W'(1);
    addrOver   = WIDE_W'(progAddr) >= sizeBytes;
    lastOver   = lastByte >= sizeBytes;
    mmAddrOver = WIDE_W'(mmAddr) >= sizeBytes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag    <= 1'b0;
      startPulse <= 1'b0;
      mmReady    <= 1'b0;
      mmBusErr   <= 1'b0;
    end else begin
      if (strb.setErr)      errFlag <= 1'b1;
      else if (strb.clrErr) errFlag <= 1'b0;
      startPulse <= strb.startXfer;
      mmReady    <= strb.mmRespond;
      mmBusErr   <= strb.mmRespond & strb.mmFault;
    end
  end

  // R5: the flag holds unless a clear arrives
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !strb.clrErr) |=> errFlag);

  // R4: a flagged access never starts a transfer
  a_r4_no_start_on_error: assert property (@(posedge clk) disable iff (!rstN)
    strb.setErr |=> !startPulse);

  // R8: one response per request cycle
  a_r8_response_follows: assert property (@(posedge clk) disable iff (!rstN)
    strb.mmRespond |=> mmReady);

  a_r8_no_spurious_response: assert property (@(posedge clk) disable iff (!rstN)
    !strb.mmRespond |=> !mmReady);

endmodule

// File: rtl/frg_ctrl.sv
module frg_ctrl
  import frg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  opMode,
  input  logic        ctrlEnable,
  input  logic        trigger,
  input  logic        clearErr,
  input  logic        mmValid,
  input  logic        addrOver,
  input  logic        lastOver,
  input  logic        lenNonZero,
  input  logic        mmAddrOver,
  output frgStrobes_t strb
);

  frgMode_e mode;
  logic     isIndirect;
  logic     isPoll;
  logic     isMmap;
  logic     accepted;
  logic     badAccess;

  always_comb begin
    mode       = frgMode_e'(opMode);
    isIndirect = (mode == MODE_IND_WR) || (mode == MODE_IND_RD);
    isPoll     = (mode == MODE_POLL);
    isMmap     = (mode == MODE_MMAP);
    accepted   = trigger && ctrlEnable && (isIndirect || isPoll);
    badAccess  = addrOver || (isIndirect && lenNonZero && lastOver);

    strb.setErr    = accepted && badAccess;
    strb.startXfer = accepted && !badAccess;
    strb.clrErr    = clearErr;
    strb.mmRespond = mmValid;
    strb.mmFault   = !ctrlEnable || !isMmap || mmAddrOver;
  end

  // R4: an access either starts or is flagged, never both
  a_r4_start_xor_error: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setErr && strb.startXfer));

  // R7: a trigger while disabled produces neither strobe
  a_r7_disabled_ignored: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEnable |-> !(strb.setErr || strb.startXfer));

endmodule

// File: rtl/flashRangeGuard.sv
module flashRangeGuard
  import frg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] sizeCode,
  input  logic [1:0]        opMode,
  input  logic              ctrlEnable,
  input  logic              errIntEnable,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic              trigger,
  input  logic              clearErr,
  output logic              xferStart,
  output logic              xferErrFlag,
  output logic              xferErrIrq,
  input  logic              mmValid,
  input  logic [ADDR_W-1:0] mmAddr,
  output logic              mmReady,
  output logic              mmBusErr
);

  frgStrobes_t strb;
  logic addrOver, lastOver, lenNonZero, mmAddrOver;

  frg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opMode     (opMode),
    .ctrlEnable (ctrlEnable),
    .trigger    (trigger),
    .clearErr   (clearErr),
    .mmValid    (mmValid),
    .addrOver   (addrOver),
    .lastOver   (lastOver),
    .lenNonZero (lenNonZero),
    .mmAddrOver (mmAddrOver),
    .strb       (strb)
  );

  frg_datapath #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .CODE_W (CODE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sizeCode   (sizeCode),
    .progAddr   (progAddr),
    .dataLen    (dataLen),
    .mmAddr     (mmAddr),
    .strb       (strb),
    .addrOver   (addrOver),
    .lastOver   (lastOver),
    .lenNonZero (lenNonZero),
    .mmAddrOver (mmAddrOver),
    .errFlag    (xferErrFlag),
    .startPulse (xferStart),
    .mmReady    (mmReady),
    .mmBusErr   (mmBusErr)
  );

  assign xferErrIrq = xferErrFlag & errIntEnable;

  // R8: a bus error only ever rides on a response
  a_r8_err_with_ready: assert property (@(posedge clk) disable iff (!rstN)
    mmBusErr |-> mmReady);

  // R9: a request while disabled is answered with a bus error
  a_r9_disabled_buserr: assert property (@(posedge clk) disable iff (!rstN)
    (mmValid && !ctrlEnable) |=> mmBusErr);

  // R11: bus requests alone never raise the flag
  a_r11_mm_keeps_flag: assert property (@(posedge clk) disable iff (!rstN)
    (!xferErrFlag && !trigger) |=> !xferErrFlag);

endmodule

// File: tb/flashRangeGuard_test.sv
`timescale 1ns/1ps
module flashRangeGuard_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  sizeCode = '0;
  logic [1:0]  opMode = '0;
  logic        ctrlEnable = 1'b0;
  logic        errIntEnable = 1'b0;
  logic [31:0] progAddr = '0;
  logic [31:0] dataLen = '0;
  logic        trigger = 1'b0;
  logic        clearErr = 1'b0;
  logic        mmValid = 1'b0;
  logic [31:0] mmAddr = '0;
  logic        xferStart, xferErrFlag, xferErrIrq, mmReady, mmBusErr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flashRangeGuard uut (
    .clk(clk), .rstN(rstN), .sizeCode(sizeCode), .opMode(opMode),
    .ctrlEnable(ctrlEnable), .errIntEnable(errIntEnable),
    .progAddr(progAddr), .dataLen(dataLen), .trigger(trigger),
    .clearErr(clearErr), .xferStart(xferStart), .xferErrFlag(xferErrFlag),
    .xferErrIrq(xferErrIrq), .mmValid(mmValid), .mmAddr(mmAddr),
    .mmReady(mmReady), .mmBusErr(mmBusErr)
  );

  // code, mode, addr, len, expected error, expected start
  localparam logic [72:0] VECS [11] = '{
    {5'd9,  2'd1, 32'd0,          32'd1024,       1'b0, 1'b1},
    {5'd9,  2'd1, 32'd0,          32'd1025,       1'b1, 1'b0},
    {5'd9,  2'd0, 32'd1023,       32'd1,          1'b0, 1'b1},
    {5'd9,  2'd0, 32'd1024,       32'd0,          1'b1, 1'b0},
    {5'd9,  2'd2, 32'd1000,       32'd100,        1'b0, 1'b1},
    {5'd9,  2'd2, 32'd1024,       32'd0,          1'b1, 1'b0},
    {5'd31, 2'd1, 32'hFFFF_FFFF,  32'd1,          1'b0, 1'b1},
    {5'd31, 2'd1, 32'hFFFF_FFFF,  32'd2,          1'b1, 1'b0},
    {5'd0,  2'd1, 32'd1,          32'd1,          1'b0, 1'b1},
    {5'd0,  2'd1, 32'd2,          32'd0,          1'b1, 1'b0},
    {5'd0,  2'd0, 32'd0,          32'hFFFF_FFFF,  1'b1, 1'b0}
  };

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic pulseClear();
    clearErr = 1'b1;
    @(negedge clk);
    clearErr = 1'b0;
  endtask

  task automatic fire(input logic [4:0] c, input logic [1:0] m,
                      input logic [31:0] a, input logic [31:0] l);
    sizeCode = c; opMode = m; progAddr = a; dataLen = l;
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  task automatic busReq(input logic [1:0] m, input logic [31:0] a);
    opMode = m; mmAddr = a; mmValid = 1'b1;
    @(negedge clk);
    mmValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(xferErrFlag, 1'b0, "R10 flag in reset");
    check(xferStart,   1'b0, "R10 start in reset");
    check(mmReady,     1'b0, "R10 ready in reset");
    check(mmBusErr,    1'b0, "R10 buserr in reset");
    rstN = 1'b1;
    ctrlEnable = 1'b1;
    errIntEnable = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R6
    foreach (VECS[i]) begin
      pulseClear();
      fire(VECS[i][72:68], VECS[i][67:66], VECS[i][65:34], VECS[i][33:2]);
      check(xferErrFlag, VECS[i][1], $sformatf("R2/R3 vec %0d flag", i));
      check(xferStart,   VECS[i][0], $sformatf("R4 vec %0d start", i));
      check(xferErrIrq,  VECS[i][1], $sformatf("R6 vec %0d irq", i));
      check(xferErrFlag, VECS[i][1], $sformatf("R1 vec %0d size decode", i));
    end

    // R4: start pulse lasts one cycle
    pulseClear();
    fire(5'd9, 2'd1, 32'd0, 32'd4);
    @(negedge clk);
    check(xferStart, 1'b0, "R4 start single cycle");

    // R5: sticky and cleared
    fire(5'd9, 2'd1, 32'd2000, 32'd0);
    repeat (3) @(negedge clk);
    check(xferErrFlag, 1'b1, "R5 flag holds");
    pulseClear();
    check(xferErrFlag, 1'b0, "R5 flag cleared");

    // R5: set wins over clear
    clearErr = 1'b1;
    fire(5'd9, 2'd1, 32'd2000, 32'd0);
    clearErr = 1'b0;
    check(xferErrFlag, 1'b1, "R5 set beats clear");

    // R6: interrupt masked
    errIntEnable = 1'b0;
    #1;
    check(xferErrIrq, 1'b0, "R6 irq masked");
    errIntEnable = 1'b1;
    pulseClear();

    // R7: disabled and memory-mapped triggers ignored
    ctrlEnable = 1'b0;
    fire(5'd9, 2'd1, 32'd5000, 32'd0);
    check(xferErrFlag, 1'b0, "R7 disabled no flag");
    fire(5'd9, 2'd1, 32'd0, 32'd4);
    check(xferStart, 1'b0, "R7 disabled no start");
    ctrlEnable = 1'b1;
    fire(5'd9, 2'd3, 32'd5000, 32'd0);
    check(xferErrFlag, 1'b0, "R7 mmap mode no flag");
    fire(5'd9, 2'd3, 32'd0, 32'd4);
    check(xferStart, 1'b0, "R7 mmap mode no start");

    // R8: memory-mapped responses
    sizeCode = 5'd9;
    busReq(2'd3, 32'd1023);
    check(mmReady,  1'b1, "R8 ready in range");
    check(mmBusErr, 1'b0, "R8 no error in range");
    @(negedge clk);
    check(mmReady, 1'b0, "R8 ready single cycle");
    busReq(2'd3, 32'd1024);
    check(mmReady,  1'b1, "R8 ready out of range");
    check(mmBusErr, 1'b1, "R8 error out of range");
    check(xferErrFlag, 1'b0, "R11 flag untouched by bus error");

    // R9: wrong mode or disabled
    busReq(2'd1, 32'd4);
    check(mmBusErr, 1'b1, "R9 wrong mode error");
    ctrlEnable = 1'b0;
    busReq(2'd3, 32'd4);
    check(mmBusErr, 1'b1, "R9 disabled error");
    check(xferErrFlag, 1'b0, "R11 flag still clear");
    ctrlEnable = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule